// File: doc/BRIEF.md
# Accumulator ALU with status flags

This block is the 8-bit arithmetic and logic stage of a small accumulator-based microcontroller core. Each cycle it receives the accumulator byte, a second operand byte, the current carry (C), auxiliary carry (AC) and overflow (OV) flags, and a 4-bit operation code. It computes a new result byte and new flag values, and writes them into output registers on a clock enable. The output registers hold their values while the enable is low.

The flag behaviour follows the conventions of classic 8-bit controllers. AC comes from the nibble boundary. OV is the carry into the top bit XOR the carry out of it. Subtraction always consumes C as a borrow. Increment and decrement touch no flag. Logic, clear, plain rotate and swap operations pass all three flags through unchanged. The two rotates through carry form a 9-bit ring with C. A decimal-adjust operation corrects the accumulator after a BCD addition.

Instruction decode, operand fetch and storage are outside this block. The core feeds its flag register into `c_i`/`ac_i`/`ov_i` and takes `c_o`/`ac_o`/`ov_o` back.

Top module: `acc_alu`

## Requirements
- R1: While `rst` is high at a clock edge, `res_o`, `c_o`, `ac_o` and `ov_o` are cleared to 0 at that edge.
- R2: When `en_i` is low at a clock edge, all four outputs keep their values. When `en_i` is high, the outputs take the result of the operation presented on that edge, visible after the edge (latency one cycle).
- R3: Op 0 (add) and op 1 (add with carry) produce `(acc + opnd + cin) mod 256`, with cin = 0 for op 0 and `c_i` for op 1. C is set when the unsigned sum exceeds 255. AC is set when the low-nibble sum plus cin exceeds 15. For example, 0x3F + 0xD3 gives 0x12 with C=1, AC=1, OV=0.
- R4: For ops 0, 1 and 2, OV is set when the signed result falls outside -128..+127, which is the same as the carry out of bit 6 differing from the carry out of bit 7.
- R5: Op 2 (subtract with borrow) produces `(acc - opnd - c_i) mod 256`. C is set when the unsigned subtraction needs a borrow. AC is set when the low nibble needs a borrow.
- R6: Op 3 (increment) and op 4 (decrement) produce `acc + 1` and `acc - 1` modulo 256. They pass C, AC and OV through unchanged.
- R7: Op 5 (AND), op 6 (OR), op 7 (XOR), op 8 (complement of acc) and op 9 (clear to 0x00) pass C, AC and OV through unchanged.
- R8: Op 10 rotates acc left by one (bit 7 enters bit 0). Op 11 rotates acc right by one (bit 0 enters bit 7). Op 14 exchanges bits 3:0 with bits 7:4. All three pass the flags through unchanged.
- R9: Op 12 rotates left through carry: bit 7 goes to C and the old C enters bit 0. Op 13 rotates right through carry: bit 0 goes to C and the old C enters bit 7. Both leave AC and OV unchanged.
- R10: Op 15 (decimal adjust) first adds 0x06 when the low nibble is above 9 or AC=1. It then adds 0x60 when the high nibble is above 9, C=1, or the first step carried out. C becomes set if either step carries out and is never cleared. AC and OV are unchanged. For example, 0x4C adjusts to 0x52.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Write enable for result and flags |
| op_i | input | 4 | Operation code (0..15, see requirements) |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand |
| c_i | input | 1 | Incoming carry / borrow flag |
| ac_i | input | 1 | Incoming auxiliary carry flag |
| ov_i | input | 1 | Incoming overflow flag |
| res_o | output | 8 | Registered result byte |
| c_o | output | 1 | Registered carry flag |
| ac_o | output | 1 | Registered auxiliary carry flag |
| ov_o | output | 1 | Registered overflow flag |

## Verification
The hardest case to reach is decimal adjust with both corrections firing, where the low-nibble fix itself carries into the high nibble. Another is the fix carrying out of the byte so that C gets set while the incoming C was 0. The stimulus drives these directly with chosen bytes and AC values, such as 0x9A and 0x99 with AC=1. Pass-through of flags is shown by giving each logic, rotate and step operation an uncommon mix of incoming C, AC and OV and checking that exactly that mix comes back. A seeded pseudo-random sweep then covers every opcode against an arithmetic model written with integers.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUBB = 4'd2,
    OP_INC  = 4'd3,
    OP_DEC  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_CPL  = 4'd8,
    OP_CLR  = 4'd9,
    OP_RL   = 4'd10,
    OP_RR   = 4'd11,
    OP_RLC  = 4'd12,
    OP_RRC  = 4'd13,
    OP_SWAP = 4'd14,
    OP_DA   = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic c;
    logic ac;
    logic ov;
  } alu_flags_t;

endpackage

// File: rtl/alu_arith.sv
module alu_arith
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e             op,
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   b,
  input  alu_flags_t          flg_i,
  output logic [DATA_W-1:0]   res,
  output alu_flags_t          flg_o
);
  localparam int NIB_W = DATA_W / 2;

  logic [DATA_W-1:0] addend;
  logic              cin;
  logic [NIB_W:0]    lo_sum;
  logic [DATA_W-1:0] mid_sum;
  logic [DATA_W:0]   full_sum;
  logic              c_top, c_mid, c_lo;

  // one shared adder; subtraction uses the inverted operand and inverted borrow
  always_comb begin
    addend = b;
    cin    = 1'b0;
    unique case (op)
      OP_ADDC: cin = flg_i.c;
      OP_SUBB: begin addend = ~b; cin = ~flg_i.c; end
      OP_INC:  begin addend = '0; cin = 1'b1; end
      OP_DEC:  begin addend = '1; cin = 1'b0; end
      default: ;
    endcase
  end

  assign lo_sum   = {1'b0, a[NIB_W-1:0]} + {1'b0, addend[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
  assign mid_sum  = {1'b0, a[DATA_W-2:0]} + {1'b0, addend[DATA_W-2:0]} + {{(DATA_W-1){1'b0}}, cin};
  assign full_sum = {1'b0, a} + {1'b0, addend} + {{DATA_W{1'b0}}, cin};
  assign c_top    = full_sum[DATA_W];
  assign c_mid    = mid_sum[DATA_W-1];
  assign c_lo     = lo_sum[NIB_W];
  assign res      = full_sum[DATA_W-1:0];

  always_comb begin
    flg_o = flg_i;
    if (op == OP_ADD || op == OP_ADDC) begin
      flg_o.c  = c_top;
      flg_o.ac = c_lo;
      flg_o.ov = c_mid ^ c_top;
    end else if (op == OP_SUBB) begin
      flg_o.c  = ~c_top;
      flg_o.ac = ~c_lo;
      flg_o.ov = c_mid ^ c_top;
    end
  end
endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e             op,
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   b,
  input  alu_flags_t          flg_i,
  output logic [DATA_W-1:0]   res,
  output alu_flags_t          flg_o
);
  localparam int NIB_W = DATA_W / 2;

  always_comb begin
    flg_o = flg_i;
    res   = a;
    unique case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_CPL:  res = ~a;
      OP_CLR:  res = '0;
      OP_RL:   res = {a[DATA_W-2:0], a[DATA_W-1]};
      OP_RR:   res = {a[0], a[DATA_W-1:1]};
      OP_RLC:  begin res = {a[DATA_W-2:0], flg_i.c}; flg_o.c = a[DATA_W-1]; end
      OP_RRC:  begin res = {flg_i.c, a[DATA_W-1:1]}; flg_o.c = a[0]; end
      OP_SWAP: res = {a[NIB_W-1:0], a[DATA_W-1:NIB_W]};
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_bcd.sv
module alu_bcd
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0]   a,
  input  alu_flags_t          flg_i,
  output logic [DATA_W-1:0]   res,
  output alu_flags_t          flg_o
);
  localparam int NIB_W = DATA_W / 2;
  localparam logic [DATA_W:0] LO_ADJ = (DATA_W+1)'(6);
  localparam logic [DATA_W:0] HI_ADJ = LO_ADJ << NIB_W;
  localparam logic [NIB_W-1:0] DIGIT_MAX = NIB_W'(9);

  logic            lo_fix, hi_fix;
  logic [DATA_W:0] step1, step2;

  assign lo_fix = (a[NIB_W-1:0] > DIGIT_MAX) || flg_i.ac;
  assign step1  = {1'b0, a} + (lo_fix ? LO_ADJ : '0);
  assign hi_fix = (step1[DATA_W-1:NIB_W] > DIGIT_MAX) || flg_i.c || step1[DATA_W];
  assign step2  = {1'b0, step1[DATA_W-1:0]} + (hi_fix ? HI_ADJ : '0);
  assign res    = step2[DATA_W-1:0];

  always_comb begin
    flg_o   = flg_i;
    flg_o.c = flg_i.c | step1[DATA_W] | step2[DATA_W];
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OP_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic              c_i,
  input  logic              ac_i,
  input  logic              ov_i,
  output logic [DATA_W-1:0] res_o,
  output logic              c_o,
  output logic              ac_o,
  output logic              ov_o
);
  alu_op_e           op;
  alu_flags_t        flg_in;
  logic [DATA_W-1:0] ar_res, bo_res, da_res, nxt_res;
  alu_flags_t        ar_flg, bo_flg, da_flg, nxt_flg;

  assign op     = alu_op_e'(op_i);
  assign flg_in = '{c: c_i, ac: ac_i, ov: ov_i};

  alu_arith #(.DATA_W(DATA_W)) u_arith (
    .op(op), .a(acc_i), .b(opnd_i), .flg_i(flg_in), .res(ar_res), .flg_o(ar_flg));

  alu_bitops #(.DATA_W(DATA_W)) u_bitops (
    .op(op), .a(acc_i), .b(opnd_i), .flg_i(flg_in), .res(bo_res), .flg_o(bo_flg));

  alu_bcd #(.DATA_W(DATA_W)) u_bcd (
    .a(acc_i), .flg_i(flg_in), .res(da_res), .flg_o(da_flg));

  always_comb begin
    if (op == OP_DA) begin
      nxt_res = da_res; nxt_flg = da_flg;
    end else if (op <= OP_DEC) begin
      nxt_res = ar_res; nxt_flg = ar_flg;
    end else begin
      nxt_res = bo_res; nxt_flg = bo_flg;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o <= '0;
      c_o   <= 1'b0;
      ac_o  <= 1'b0;
      ov_o  <= 1'b0;
    end else if (en_i) begin
      res_o <= nxt_res;
      c_o   <= nxt_flg.c;
      ac_o  <= nxt_flg.ac;
      ov_o  <= nxt_flg.ov;
    end
  end

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> $stable(res_o) && $stable(c_o) && $stable(ac_o) && $stable(ov_o));

  // R3
  add_sum_chk: assert property (@(posedge clk) disable iff (rst)
    en_i && op == OP_ADD |=> {c_o, res_o} == ({1'b0, $past(acc_i)} + {1'b0, $past(opnd_i)}));

  // R5
  subb_diff_chk: assert property (@(posedge clk) disable iff (rst)
    en_i && op == OP_SUBB |=>
      res_o == ($past(acc_i) - $past(opnd_i) - {{(DATA_W-1){1'b0}}, $past(c_i)}));

  // R6
  step_keeps_flags_chk: assert property (@(posedge clk) disable iff (rst)
    en_i && (op == OP_INC || op == OP_DEC) |=>
      c_o == $past(c_i) && ac_o == $past(ac_i) && ov_o == $past(ov_i));

  // R7
  logic_keeps_flags_chk: assert property (@(posedge clk) disable iff (rst)
    en_i && op >= OP_AND && op <= OP_CLR |=>
      c_o == $past(c_i) && ac_o == $past(ac_i) && ov_o == $past(ov_i));

  // R9
  rlc_carry_chk: assert property (@(posedge clk) disable iff (rst)
    en_i && op == OP_RLC |=> c_o == $past(acc_i[DATA_W-1]) && res_o[0] == $past(c_i));

  // R10
  da_never_clears_chk: assert property (@(posedge clk) disable iff (rst)
    en_i && op == OP_DA && c_i |=> c_o);
endmodule

// File: tb/test_acc_alu.sv
`timescale 1ns/1ps
module test_acc_alu;
  typedef struct {
    logic [7:0] r;
    logic c, ac, ov;
    string tag;
    int cyc;
  } exp_t;

  logic clk = 1'b0, rst = 1'b1, en_i = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] acc_i = '0, opnd_i = '0;
  logic c_i = 1'b0, ac_i = 1'b0, ov_i = 1'b0;
  logic [7:0] res_o;
  logic c_o, ac_o, ov_o;

  int errs = 0, checks = 0, cyc = 0;
  exp_t sbq[$];
  logic [7:0] m_r = '0;
  logic m_c = 1'b0, m_ac = 1'b0, m_ov = 1'b0;

  acc_alu i_acc_alu (.clk(clk), .rst(rst), .en_i(en_i), .op_i(op_i), .acc_i(acc_i),
    .opnd_i(opnd_i), .c_i(c_i), .ac_i(ac_i), .ov_i(ov_i),
    .res_o(res_o), .c_o(c_o), .ac_o(ac_o), .ov_o(ov_o));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic string tag_of(input int op);
    case (op)
      0, 1: return "R3";
      2: return "R5";
      3, 4: return "R6";
      5, 6, 7, 8, 9: return "R7";
      10, 11, 14: return "R8";
      12, 13: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic model(input int op, input int a, input int b, input int c, input int ac,
                       input int ov, output int r, output int co, output int aco, output int ovo);
    int sa, sb, t;
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    co = c; aco = ac; ovo = ov; r = a;
    case (op)
      0, 1: begin
        t = (op == 1) ? c : 0;
        r = (a + b + t) % 256; co = (a + b + t > 255);
        aco = ((a % 16) + (b % 16) + t > 15);
        ovo = (sa + sb + t > 127) || (sa + sb + t < -128);
      end
      2: begin
        r = (a - b - c + 512) % 256; co = (a - b - c < 0);
        aco = ((a % 16) - (b % 16) - c < 0);
        ovo = (sa - sb - c > 127) || (sa - sb - c < -128);
      end
      3: r = (a + 1) % 256;
      4: r = (a + 255) % 256;
      5: r = a & b;
      6: r = a | b;
      7: r = a ^ b;
      8: r = 255 - a;
      9: r = 0;
      10: r = ((a * 2) % 256) + a / 128;
      11: r = a / 2 + (a % 2) * 128;
      12: begin r = ((a * 2) % 256) + c; co = a / 128; end
      13: begin r = a / 2 + c * 128; co = a % 2; end
      14: r = (a % 16) * 16 + a / 16;
      default: begin
        t = a;
        if ((t % 16) > 9 || ac == 1) t = t + 6;
        if (t > 255) begin co = 1; t = t - 256; end
        if ((t / 16) > 9 || co == 1) t = t + 96;
        if (t > 255) begin co = 1; t = t - 256; end
        r = t;
      end
    endcase
  endtask

  task automatic drive(input int op, input int a, input int b, input logic c, input logic ac,
                       input logic ov, input logic en);
    exp_t e;
    int r, co, aco, ovo;
    @(negedge clk);
    op_i = 4'(op); acc_i = 8'(a); opnd_i = 8'(b);
    c_i = c; ac_i = ac; ov_i = ov; en_i = en;
    if (en) begin
      model(op, a, b, int'(c), int'(ac), int'(ov), r, co, aco, ovo);
      m_r = 8'(r); m_c = co[0]; m_ac = aco[0]; m_ov = ovo[0];
    end
    e.r = m_r; e.c = m_c; e.ac = m_ac; e.ov = m_ov;
    e.tag = en ? tag_of(op) : "R2";
    e.cyc = cyc;
    sbq.push_back(e);
  endtask

  // monitor: compares each expected item one clock edge after it was driven
  always @(negedge clk) begin
    if (sbq.size() > 0 && sbq[0].cyc < cyc) begin
      exp_t e;
      e = sbq.pop_front();
      checks++;
      if (res_o !== e.r || c_o !== e.c || ac_o !== e.ac || ov_o !== e.ov) begin
        errs++;
        $display("FAIL %s: got r=%02h c=%0b ac=%0b ov=%0b, expected r=%02h c=%0b ac=%0b ov=%0b",
                 e.tag, res_o, c_o, ac_o, ov_o, e.r, e.c, e.ac, e.ov);
      end
    end
  end

  initial begin
    #(200000 * 5);
    errs++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    int unsigned seed;
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (res_o !== 8'h00 || c_o !== 1'b0 || ac_o !== 1'b0 || ov_o !== 1'b0) begin
      errs++;
      $display("FAIL R1: got r=%02h c=%0b ac=%0b ov=%0b, expected all zero", res_o, c_o, ac_o, ov_o);
    end
    @(negedge clk); rst = 1'b0;

    // R3 / R4 add cases
    drive(0, 8'h3F, 8'hD3, 1, 0, 0, 1);
    drive(0, 8'h7F, 8'h73, 0, 0, 0, 1);
    drive(0, 8'h8F, 8'hD3, 0, 0, 0, 1);
    drive(1, 8'h0F, 8'h00, 1, 0, 1, 1);
    drive(1, 8'hFF, 8'h00, 1, 0, 0, 1);
    // R2 hold with enable low
    drive(0, 8'hFF, 8'hFF, 1, 1, 1, 0);
    drive(8, 8'h55, 8'h00, 0, 0, 0, 0);
    // R5 / R4 subtract with borrow
    drive(2, 8'h00, 8'h01, 0, 0, 0, 1);
    drive(2, 8'h50, 8'h20, 1, 0, 0, 1);
    drive(2, 8'h80, 8'h01, 0, 0, 0, 1);
    drive(2, 8'h10, 8'h01, 0, 0, 1, 1);
    // R6 step operations with flags set
    drive(3, 8'hFF, 8'h00, 1, 0, 1, 1);
    drive(4, 8'h00, 8'h00, 0, 1, 0, 1);
    // R7 logic with odd flag mixes
    drive(5, 8'hAC, 8'h0F, 1, 0, 1, 1);
    drive(6, 8'hAC, 8'h0F, 0, 1, 1, 1);
    drive(7, 8'hAC, 8'h0F, 1, 1, 0, 1);
    drive(8, 8'hAC, 8'h00, 0, 0, 1, 1);
    drive(9, 8'hAC, 8'h00, 1, 1, 1, 1);
    // R8 plain rotates and swap
    drive(10, 8'hF0, 8'h00, 0, 1, 0, 1);
    drive(11, 8'h01, 8'h00, 1, 0, 1, 1);
    drive(14, 8'h72, 8'h00, 0, 1, 1, 1);
    // R9 rotates through carry
    drive(12, 8'h3C, 8'h00, 1, 0, 1, 1);
    drive(13, 8'hBD, 8'h00, 0, 1, 0, 1);
    drive(12, 8'h80, 8'h00, 0, 0, 0, 1);
    // R10 decimal adjust corners
    drive(15, 8'h4C, 8'h00, 0, 0, 0, 1);
    drive(15, 8'h9A, 8'h00, 0, 0, 1, 1);
    drive(15, 8'h99, 8'h00, 0, 1, 0, 1);
    drive(15, 8'h12, 8'h00, 1, 1, 0, 1);
    drive(15, 8'h34, 8'h00, 1, 0, 0, 1);
    // pseudo-random sweep over all operations
    seed = 32'h1234_5678;
    for (int i = 0; i < 600; i++) begin
      seed = seed * 1103515245 + 12345;
      drive(int'(seed[27:24]), int'(seed[23:16]), int'(seed[15:8]),
            seed[3], seed[5], seed[7], seed[30] | seed[29]);
    end
    repeat (3) @(negedge clk);
    checks++;
    if (sbq.size() != 0) begin
      errs++;
      $display("FAIL R2: got %0d unchecked results, expected 0", sbq.size());
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule